// File: doc/BRIEF.md
# Biphase-Mark Stereo Sub-Frame Serializer

This block turns one stereo sample pair per frame into a continuous single-wire serial stream. Each frame carries two 32-slot sub-frames, channel A first and then channel B. A sub-frame opens with a fixed sync pattern that is already line-coded. The other 28 slots follow in biphase-mark code: 24 audio bits sent least significant first, then the validity, user and status flags, then an even-parity bit. The line moves one half-cell on each pulse of `bp_en`, which the surrounding logic supplies at twice the bit-cell rate.

The producer drives both channels' samples and flags, then waits for `next_req`. That strobe fires when channel A starts. At that moment the block has captured everything it needs for the frame, and the inputs may change. Channel B's audio word and its three flags wait inside the block while channel A is sent. No external path can reach those held copies. A block-start input forces the channel A sync pattern that marks the first frame of a block. After that, the block inserts the same pattern on its own every `BLOCK_FRAMES` frames.

Top module: `spdif_serializer`

## Requirements
- R1: A sub-frame lasts 64 half-cells. Its first 8 half-cells are the sync pattern, sent most significant bit first. That pattern's first half-cell is always 0.
- R2: The channel A sync pattern is 00011101. The channel B pattern is 00011011. The block-start pattern 00010111 replaces the channel A pattern in the first frame of a block.
- R3: The first frame after reset uses the block-start pattern. So does any frame accepted while `blk_start` is 1. Without `blk_start`, the pattern recurs `BLOCK_FRAMES` frames after the previous one.
- R4: Slots 4 to 27 carry the 24-bit audio word, bit 0 first. Slot 28 carries validity, slot 29 user and slot 30 status.
- R5: Slot 31 holds a parity bit that gives slots 4 to 31 an even number of ones. As a result the line sits at 1 in the last half-cell of every sub-frame.
- R6: Each payload slot starts with a line transition, including the transition from the sync pattern into slot 4. A second transition at mid-cell encodes a 1; a 0 has none.
- R7: Channel B's audio word and flags are captured when channel A starts. Changes on the channel B inputs after that point do not affect the channel B sub-frame being sent.
- R8: `next_req` is a one-cycle pulse. It rises once per frame, in the cycle after channel A starts, when the line is at half-cell 0 of channel A.
- R9: During reset `sdo` and `next_req` are 0. Transmission begins with channel A at the first `bp_en` after reset.
- R10: `sdo` changes only on a clock edge where `bp_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_en | input | 1 | Half-cell advance enable |
| blk_start | input | 1 | Force block-start sync in the frame being accepted |
| a_audio | input | 24 | Channel A audio word |
| b_audio | input | 24 | Channel B audio word |
| a_valid | input | 1 | Channel A validity flag |
| a_user | input | 1 | Channel A user bit |
| a_status | input | 1 | Channel A status bit |
| b_valid | input | 1 | Channel B validity flag |
| b_user | input | 1 | Channel B user bit |
| b_status | input | 1 | Channel B status bit |
| sdo | output | 1 | Biphase-mark serial line |
| next_req | output | 1 | One-cycle request for the next frame's data |

## Verification
Some rules are checked on every cycle:
- the line holds still between enables;
- every sub-frame begins at 0;
- every payload cell opens with a transition;
- every sub-frame ends at level 1, which confirms the parity;
- the request strobe is a single-cycle pulse aligned to the start of channel A.

Other behaviour can only be shown by the bench's scenarios, which decode the line back into words:
- the exact sync codes;
- the block-start cadence, both the forced case and the counted one;
- the bit order and flag slots;
- channel B values held across input changes during channel A.

// File: rtl/spdif_pkg.sv
package spdif_pkg;
  localparam int AUD_W      = 24;
  localparam int SUB_HALVES = 64;
  localparam int PRE_HALVES = 8;
  localparam int PAY_BITS   = AUD_W + 4;
  localparam int POS_W      = $clog2(SUB_HALVES);

  typedef enum logic [1:0] {
    PK_X = 2'd0,
    PK_Y = 2'd1,
    PK_Z = 2'd2
  } pre_kind_t;

  // packed: v at bit 0, u at bit 1, c at bit 2
  typedef struct packed {
    logic c;
    logic u;
    logic v;
  } nad_t;

  // Sync patterns are already in line-coded form.
  function automatic logic [PRE_HALVES-1:0] pre_code(pre_kind_t k);
    case (k)
      PK_Y:    return 8'b0001_1011;
      PK_Z:    return 8'b0001_0111;
      default: return 8'b0001_1101;
    endcase
  endfunction

  // Payload word, bit 0 goes out first (slot 4), parity on top (slot 31).
  function automatic logic [PAY_BITS-1:0] build_payload(logic [AUD_W-1:0] aud, nad_t n);
    logic [PAY_BITS-2:0] body;
    body = {n, aud};
    return {^body, body};
  endfunction
endpackage

// File: rtl/spdif_slot_seq.sv
module spdif_slot_seq
  import spdif_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_en,
  input  logic             blk_start,
  output logic             active,
  output logic [POS_W-1:0] pos,
  output logic             chan_b,
  output logic             load,
  output logic             load_a,
  output logic             load_b,
  output pre_kind_t        kind
);
  localparam int CW = $clog2(BLOCK_FRAMES + 1);

  logic [CW-1:0] fcnt, fcnt_nxt;
  logic          end_sub;
  logic          z_due;

  always_comb begin
    end_sub  = active && (pos == POS_W'(SUB_HALVES - 1));
    load     = bp_en && (!active || end_sub);
    load_b   = load && active && !chan_b;
    load_a   = load && !load_b;
    z_due    = blk_start || (fcnt == '0);
    kind     = load_b ? PK_Y : (z_due ? PK_Z : PK_X);
    fcnt_nxt = z_due ? CW'(1) : fcnt + CW'(1);
    if (fcnt_nxt == CW'(BLOCK_FRAMES)) fcnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      chan_b <= 1'b0;
      fcnt   <= '0;
    end else if (load) begin
      active <= 1'b1;
      pos    <= '0;
      chan_b <= load_b;
      if (load_a) fcnt <= fcnt_nxt;
    end else if (bp_en && active) begin
      pos <= pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/spdif_payload_asm.sv
module spdif_payload_asm
  import spdif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_en,
  input  logic             active,
  input  logic [POS_W-1:0] pos,
  input  logic             load_a,
  input  logic             load_b,
  input  logic [AUD_W-1:0] a_aud,
  input  logic [AUD_W-1:0] b_aud,
  input  nad_t             a_nad,
  input  nad_t             b_nad,
  output logic             cur_bit
);
  logic [PAY_BITS-1:0] sr;
  logic [AUD_W-1:0]    b_aud_buf;
  nad_t                b_nad_hold;
  logic                shift;

  // advance after the second half of each payload cell except the last
  assign shift   = bp_en && active && !load_a && !load_b && pos[0] &&
                   (pos >= POS_W'(PRE_HALVES + 1));
  assign cur_bit = sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr         <= '0;
      b_aud_buf  <= '0;
      b_nad_hold <= '0;
    end else if (load_a) begin
      sr         <= build_payload(a_aud, a_nad);
      b_aud_buf  <= b_aud;
      b_nad_hold <= b_nad;
    end else if (load_b) begin
      sr <= build_payload(b_aud_buf, b_nad_hold);
    end else if (shift) begin
      sr <= {1'b0, sr[PAY_BITS-1:1]};
    end
  end
endmodule

// File: rtl/spdif_bmc_line.sv
module spdif_bmc_line
  import spdif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_en,
  input  logic             active,
  input  logic [POS_W-1:0] pos,
  input  logic             load,
  input  pre_kind_t        kind,
  input  logic             cur_bit,
  output logic             sdo
);
  logic [PRE_HALVES-1:0] pre_sr;
  logic [PRE_HALVES-1:0] code;
  logic                  in_pre;
  logic                  cell_edge;

  assign code      = pre_code(kind);
  assign in_pre    = pos < POS_W'(PRE_HALVES - 1);
  assign cell_edge = pos[0];   // next half-cell is even: a new cell begins

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_sr <= '0;
      sdo    <= 1'b0;
    end else if (load) begin
      sdo    <= code[PRE_HALVES-1];
      pre_sr <= {code[PRE_HALVES-2:0], 1'b0};
    end else if (bp_en && active) begin
      if (in_pre) begin
        sdo    <= pre_sr[PRE_HALVES-1];
        pre_sr <= {pre_sr[PRE_HALVES-2:0], 1'b0};
      end else if (cell_edge) begin
        sdo <= ~sdo;
      end else if (cur_bit) begin
        sdo <= ~sdo;
      end
    end
  end
endmodule

// File: rtl/spdif_serializer.sv
module spdif_serializer
  import spdif_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bp_en,
  input  logic        blk_start,
  input  logic [23:0] a_audio,
  input  logic [23:0] b_audio,
  input  logic        a_valid,
  input  logic        a_user,
  input  logic        a_status,
  input  logic        b_valid,
  input  logic        b_user,
  input  logic        b_status,
  output logic        sdo,
  output logic        next_req
);
  logic             active;
  logic [POS_W-1:0] pos;
  logic             chan_b;
  logic             load, load_a, load_b;
  pre_kind_t        kind;
  logic             cur_bit;
  nad_t             a_nad, b_nad;

  assign a_nad = '{c: a_status, u: a_user, v: a_valid};
  assign b_nad = '{c: b_status, u: b_user, v: b_valid};

  spdif_slot_seq #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .blk_start(blk_start),
    .active(active), .pos(pos), .chan_b(chan_b),
    .load(load), .load_a(load_a), .load_b(load_b), .kind(kind)
  );

  spdif_payload_asm u_asm (
    .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .active(active), .pos(pos),
    .load_a(load_a), .load_b(load_b),
    .a_aud(a_audio), .b_aud(b_audio), .a_nad(a_nad), .b_nad(b_nad),
    .cur_bit(cur_bit)
  );

  spdif_bmc_line u_line (
    .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .active(active), .pos(pos),
    .load(load), .kind(kind), .cur_bit(cur_bit), .sdo(sdo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) next_req <= 1'b0;
    else        next_req <= load_a;
  end
endmodule

// File: rtl/spdif_serializer_chk.sv
module spdif_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bp_en,
  input logic       sdo,
  input logic       next_req,
  input logic       active,
  input logic [5:0] pos,
  input logic       chan_b
);
  a_r10_line_still: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_en |=> $stable(sdo));

  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |=> !next_req);

  a_r8_req_at_a_start: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |-> (active && !chan_b && pos == 6'd0));

  a_r1_sync_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos == 6'd0) |-> !sdo);

  a_r6_cell_transition: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_en && active && pos[0] && pos >= 6'd7 && pos != 6'd63) |=> (sdo != $past(sdo)));

  a_r5_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos == 6'd63) |-> sdo);
endmodule

bind spdif_serializer spdif_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .sdo(sdo), .next_req(next_req),
  .active(active), .pos(pos), .chan_b(chan_b)
);

// File: tb/spdif_serializer_bench.sv
`timescale 1ns/1ps
module spdif_serializer_bench;
  localparam int BF = 4;
  localparam int NF = 12;
  localparam int BLK_FRAME = 6;

  logic clk = 1'b0;
  logic rst_n, bp_en, blk_start;
  logic [23:0] a_audio, b_audio;
  logic a_valid, a_user, a_status, b_valid, b_user, b_status;
  logic sdo, next_req;

  int checks = 0;
  int errors = 0;
  int nreq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spdif_serializer #(.BLOCK_FRAMES(BF)) u_spdif_serializer (
    .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .blk_start(blk_start),
    .a_audio(a_audio), .b_audio(b_audio),
    .a_valid(a_valid), .a_user(a_user), .a_status(a_status),
    .b_valid(b_valid), .b_user(b_user), .b_status(b_status),
    .sdo(sdo), .next_req(next_req)
  );

  function automatic logic [23:0] aud_of(int f, bit chb);
    logic [23:0] v;
    case (f % 4)
      0: v = 24'h000000;
      1: v = 24'hFFFFFF;
      2: v = 24'hA5A5A5 ^ 24'(f);
      default: v = 24'(f * 32'h01357B);
    endcase
    return chb ? (~v ^ 24'(f << 3)) : v;
  endfunction

  // {status, user, valid}
  function automatic logic [2:0] nad_of(int f, bit chb);
    return chb ? (3'(f) ^ 3'b101) : 3'(f);
  endfunction

  function automatic logic [7:0] sync_of(int kind);
    if (kind == 1) return 8'h1B;       // channel B
    else if (kind == 2) return 8'h17;  // block start
    else return 8'h1D;                 // channel A
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int f);
    a_audio   = aud_of(f, 1'b0);
    b_audio   = aud_of(f, 1'b1);
    {a_status, a_user, a_valid} = nad_of(f, 1'b0);
    {b_status, b_user, b_valid} = nad_of(f, 1'b1);
    blk_start = (f == BLK_FRAME);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one half-cell: enable for one clock, then one idle clock
  task automatic step(output logic s, output logic r);
    bp_en = 1'b1;
    @(negedge clk);
    bp_en = 1'b0;
    s = sdo;
    r = next_req;
    @(negedge clk);
    chk(sdo == s, "R10 line stable without enable", sdo, s);
    if (r) chk(next_req == 1'b0, "R8 request one cycle wide", next_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic h [64];
    logic s, r;
    logic [27:0] bits;
    logic [7:0] got_sync;
    int last_z;
    int kind;
    bit bnd_ok;

    rst_n = 1'b0;
    bp_en = 1'b0;
    drive(0);
    repeat (5) @(negedge clk);
    chk(sdo == 1'b0, "R9 sdo low in reset", sdo, 0);
    chk(next_req == 1'b0, "R9 req low in reset", next_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0 && next_req == 1'b0, "R9 idle before first enable", {sdo, next_req}, 0);

    last_z = 0;
    for (int f = 0; f < NF; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int k = 0; k < 64; k++) begin
          step(s, r);
          h[k] = s;
          if (r) begin
            chk(ch == 0 && k == 0, "R8 request at channel A start", (ch << 8) | k, 0);
            nreq++;
            drive(nreq);
          end
        end
        // expected sync (R2, R3)
        if (ch == 1) kind = 1;
        else if (f == 0 || f == BLK_FRAME || (f - last_z) == BF) begin
          kind = 2;
          last_z = f;
        end else kind = 0;
        for (int i = 0; i < 8; i++) got_sync[7 - i] = h[i];
        chk(got_sync == sync_of(kind), (kind == 2) ? "R3 block-start sync" : "R2 sync pattern",
            got_sync, sync_of(kind));
        chk(h[0] == 1'b0, "R1 sync begins low", h[0], 0);
        // biphase decode (R6)
        bnd_ok = 1'b1;
        for (int sl = 4; sl < 32; sl++) begin
          if (h[2*sl] == h[2*sl - 1]) bnd_ok = 1'b0;
          bits[sl - 4] = h[2*sl] ^ h[2*sl + 1];
        end
        chk(bnd_ok, "R6 transition at every cell start", bnd_ok, 1);
        chk(^bits == 1'b0, "R5 even parity slots 4-31", ^bits, 0);
        chk(h[63] == 1'b1, "R5 sub-frame ends high", h[63], 1);
        chk(bits[23:0] == aud_of(f, ch[0]), ch ? "R7 held channel B audio" : "R4 channel A audio",
            bits[23:0], aud_of(f, ch[0]));
        chk(bits[26:24] == nad_of(f, ch[0]), ch ? "R7 held channel B flags" : "R4 channel A flags",
            bits[26:24], nad_of(f, ch[0]));
      end
    end
    chk(nreq == NF, "R8 one request per frame", nreq, NF);
    done = 1;
    finish_run();
  end
endmodule